// File: doc/BRIEF.md
# Dual-Space Memory Decoder with Bank Arbitration

This block sits between the two address paths of a processor core and its internal memories. The instruction/coefficient space (X) and the data space (Y) each have a 16-bit address. Both spaces can reach a pair of shared dual-port RAM banks, and X can also reach an internal ROM. For each space the block works out which region the address falls in. It then raises the matching chip select and gives the word offset inside the selected RAM bank.

A single map bit, loaded through a configuration write, moves the regions in X space. With the bit clear, the RAM banks sit high in X space and the ROM starts at address zero. With the bit set, the RAM moves to address zero and the ROM moves up. A debug trap forces the default map. A later trap-done pulse puts back the map that was in force at trap entry.

When X and Y reach for the same RAM bank in one cycle, Y wins that cycle. The block asserts a wait to X, and in the next cycle it serves the held X access.

Top module: `xy_mem_decoder`

## Requirements
- R1: After reset the map bit is 0, no debug trap is active and `x_wait` is low.
- R2: A configuration write loads the map from bit 14 of `cfg_wdata`. The new map is visible on `map_sel` and in the decode from the next cycle on. All other data bits have no effect.
- R3: With map 0, X addresses 0xC000–0xC3FF select RAM bank 0 and 0xC400–0xC7FF select bank 1. X addresses 0x0000–0x5FFF select the ROM.
- R4: With map 1, X addresses 0x0000–0x03FF select bank 0 and 0x0400–0x07FF select bank 1. X addresses 0x4000–0x9FFF select the ROM.
- R5: In Y space the banks sit at 0x0000–0x07FF under either map, with bank 0 below 0x0400.
- R6: The RAM offset output of a space equals the low 10 address bits whenever that space has a RAM bank selected.
- R7: A space with its request low raises no chip select, and X raises no wait.
- R8: X and Y accesses to different banks are both selected in the same cycle, with no wait.
- R9: When X and Y hit the same bank and the previous cycle was not a wait, Y gets the bank, X gets no RAM select, and `x_wait` is high for that cycle.
- R10: In the cycle after a wait, `x_wait` is low and X gets its bank. A Y access to that same bank in that cycle is not selected.
- R11: A trap-entry pulse outside a trap sets `trap_active` and clears the map in the next cycle.
- R12: A trap-done pulse during a trap clears `trap_active` and restores the map held at entry. This overrides any write made during the trap. A trap entry during a trap, and a trap done outside a trap, change nothing.
- R13: When a trap entry and a configuration write come in the same cycle, the trap entry wins. The saved map is the one before the write.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data; bit 14 is the map bit |
| trap_enter | input | 1 | Debug trap entry pulse |
| trap_done | input | 1 | Debug trap service complete pulse |
| x_req | input | 1 | X-space access valid |
| x_addr | input | 16 | X-space address |
| y_req | input | 1 | Y-space access valid |
| y_addr | input | 16 | Y-space address |
| x_rom_cs | output | 1 | ROM select from X |
| x_ram_cs | output | 2 | RAM bank selects from X, one-hot |
| x_ram_offs | output | 10 | Word offset in the X-selected bank |
| y_ram_cs | output | 2 | RAM bank selects from Y, one-hot |
| y_ram_offs | output | 10 | Word offset in the Y-selected bank |
| x_wait | output | 1 | Stalls the X requester for one cycle |
| map_sel | output | 1 | Map in effect (0 RAM high, 1 RAM low) |
| trap_active | output | 1 | Debug trap in progress |

## Verification
The bench goes after region edges under both maps, such as 0x5FFF against 0x6000 and 0x3FFF against 0x4000. A decoder with an off-by-one limit, or one that ignores the map bit, would select the wrong region or none at all. It drives back-to-back same-bank collisions, where an arbiter without the one-cycle X slot would either stall X forever or grant a bank to both spaces at once. It also covers trap entry with a write in the same cycle, and a write inside a trap followed by trap done. A controller that saved the map at the wrong time, or let the write survive, would leave the wrong map after the trap.

// File: rtl/xymd_pkg.sv
`timescale 1ns/1ps
package xymd_pkg;

   typedef enum logic {
      MAP_RAM_HIGH = 1'b0,
      MAP_RAM_LOW  = 1'b1
   } map_e;

   // true when [lo_a, lo_a+span_a) and [lo_b, lo_b+span_b) do not overlap
   function automatic bit windows_apart(input longint lo_a, input longint span_a,
                                        input longint lo_b, input longint span_b);
      return (lo_a + span_a <= lo_b) || (lo_b + span_b <= lo_a);
   endfunction

endpackage

// File: rtl/xymd_map_ctrl.sv
`timescale 1ns/1ps
module xymd_map_ctrl
   import xymd_pkg::*;
#(
   parameter int CFG_W   = 16,
   parameter int MAP_BIT = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             trap_enter,
   input  logic             trap_done,
   output map_e             map_sel,
   output logic             trap_active
);

   map_e map_q;
   map_e saved_q;
   logic trap_q;
   logic cfg_unused;

   assign cfg_unused = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q   <= MAP_RAM_HIGH;
         saved_q <= MAP_RAM_HIGH;
         trap_q  <= 1'b0;
      end else if (trap_enter && !trap_q) begin
         saved_q <= map_q;
         map_q   <= MAP_RAM_HIGH;
         trap_q  <= 1'b1;
      end else if (trap_done && trap_q) begin
         map_q   <= saved_q;
         trap_q  <= 1'b0;
      end else if (cfg_wr) begin
         map_q   <= map_e'(cfg_wdata[MAP_BIT]);
      end
   end

   assign map_sel     = map_q;
   assign trap_active = trap_q;

endmodule

// File: rtl/xymd_space_dec.sv
`timescale 1ns/1ps
module xymd_space_dec
   import xymd_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int NUM_BANKS   = 2,
   parameter int BANK_WORDS  = 1024,
   parameter bit HAS_ROM     = 1'b1,
   parameter int ROM_WORDS   = 24576,
   parameter int RAM_BASE_M0 = 'hC000,
   parameter int RAM_BASE_M1 = 'h0000,
   parameter int ROM_BASE_M0 = 'h0000,
   parameter int ROM_BASE_M1 = 'h4000,
   localparam int OFFS_W     = $clog2(BANK_WORDS),
   localparam int BIDX_W     = $clog2(NUM_BANKS),
   localparam int SPAN       = NUM_BANKS * BANK_WORDS
) (
   input  logic                 req,
   input  logic [ADDR_W-1:0]    addr,
   input  map_e                 map_sel,
   output logic [NUM_BANKS-1:0] ram_hit,
   output logic [OFFS_W-1:0]    ram_offs,
   output logic                 rom_hit
);

   logic [ADDR_W-1:0] ram_base;
   logic [ADDR_W-1:0] ram_rel;
   logic              in_ram;
   logic [BIDX_W-1:0] bank_idx;

   assign ram_base = (map_sel == MAP_RAM_LOW) ? ADDR_W'(RAM_BASE_M1) : ADDR_W'(RAM_BASE_M0);
   assign ram_rel  = addr - ram_base;
   assign in_ram   = req && (ram_rel < ADDR_W'(SPAN));
   assign bank_idx = ram_rel[OFFS_W +: BIDX_W];
   assign ram_offs = ram_rel[OFFS_W-1:0];

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      assign ram_hit[g] = in_ram && (bank_idx == BIDX_W'(g));
   end

   if (HAS_ROM) begin : g_rom
      logic [ADDR_W-1:0] rom_base;
      logic [ADDR_W-1:0] rom_rel;
      assign rom_base = (map_sel == MAP_RAM_LOW) ? ADDR_W'(ROM_BASE_M1) : ADDR_W'(ROM_BASE_M0);
      assign rom_rel  = addr - rom_base;
      assign rom_hit  = req && (rom_rel < ADDR_W'(ROM_WORDS));
   end else begin : g_no_rom
      assign rom_hit = 1'b0;
   end

endmodule

// File: rtl/xymd_bank_arb.sv
`timescale 1ns/1ps
module xymd_bank_arb #(
   parameter int NUM_BANKS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] x_hit,
   input  logic [NUM_BANKS-1:0] y_hit,
   output logic [NUM_BANKS-1:0] x_grant,
   output logic [NUM_BANKS-1:0] y_grant,
   output logic                 x_wait
);

   logic                 x_slot_q;
   logic [NUM_BANKS-1:0] clash;
   logic                 conflict;

   assign clash    = x_hit & y_hit;
   assign conflict = !x_slot_q && (|clash);

   // conflict cycle: Y wins; following slot: X's held access wins
   assign x_grant  = conflict ? '0 : x_hit;
   assign y_grant  = x_slot_q ? (y_hit & ~x_hit) : y_hit;
   assign x_wait   = conflict;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) x_slot_q <= 1'b0;
      else        x_slot_q <= conflict;
   end

endmodule

// File: rtl/xy_mem_decoder.sv
`timescale 1ns/1ps
module xy_mem_decoder
   import xymd_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int CFG_W       = 16,
   parameter int MAP_BIT     = 14,
   parameter int NUM_BANKS   = 2,
   parameter int BANK_WORDS  = 1024,
   parameter int ROM_WORDS   = 24576,
   parameter int X_RAM_HIGH  = 'hC000,
   parameter int X_RAM_LOW   = 'h0000,
   parameter int X_ROM_HIGH  = 'h4000,
   parameter int X_ROM_LOW   = 'h0000,
   parameter int Y_RAM_BASE  = 'h0000,
   localparam int OFFS_W     = $clog2(BANK_WORDS),
   localparam int SPAN       = NUM_BANKS * BANK_WORDS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CFG_W-1:0]     cfg_wdata,
   input  logic                 trap_enter,
   input  logic                 trap_done,
   input  logic                 x_req,
   input  logic [ADDR_W-1:0]    x_addr,
   input  logic                 y_req,
   input  logic [ADDR_W-1:0]    y_addr,
   output logic                 x_rom_cs,
   output logic [NUM_BANKS-1:0] x_ram_cs,
   output logic [OFFS_W-1:0]    x_ram_offs,
   output logic [NUM_BANKS-1:0] y_ram_cs,
   output logic [OFFS_W-1:0]    y_ram_offs,
   output logic                 x_wait,
   output logic                 map_sel,
   output logic                 trap_active
);

   // elaboration-time parameter checks
   if (BANK_WORDS < 2 || (BANK_WORDS & (BANK_WORDS - 1)) != 0) begin : g_chk_bank
      $error("BANK_WORDS must be a power of two");
   end
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_chk_nb
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (MAP_BIT >= CFG_W) begin : g_chk_mapbit
      $error("MAP_BIT outside configuration word");
   end
   if ((X_RAM_HIGH % SPAN) != 0 || (X_RAM_LOW % SPAN) != 0 || (Y_RAM_BASE % SPAN) != 0) begin : g_chk_align
      $error("RAM bases must be aligned to the RAM span");
   end
   if (longint'(X_RAM_HIGH) + SPAN > (longint'(1) << ADDR_W) ||
       longint'(X_ROM_HIGH) + ROM_WORDS > (longint'(1) << ADDR_W) ||
       longint'(X_ROM_LOW) + ROM_WORDS > (longint'(1) << ADDR_W)) begin : g_chk_fit
      $error("region runs past the top of the address space");
   end
   if (!windows_apart(X_RAM_HIGH, SPAN, X_ROM_LOW, ROM_WORDS) ||
       !windows_apart(X_RAM_LOW, SPAN, X_ROM_HIGH, ROM_WORDS)) begin : g_chk_overlap
      $error("RAM and ROM windows overlap in one map");
   end

   map_e                 map_q;
   logic [NUM_BANKS-1:0] x_hit;
   logic [NUM_BANKS-1:0] y_hit;
   logic                 y_rom_unused;

   xymd_map_ctrl #(
      .CFG_W   (CFG_W),
      .MAP_BIT (MAP_BIT)
   ) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (cfg_wr),
      .cfg_wdata   (cfg_wdata),
      .trap_enter  (trap_enter),
      .trap_done   (trap_done),
      .map_sel     (map_q),
      .trap_active (trap_active)
   );

   xymd_space_dec #(
      .ADDR_W      (ADDR_W),
      .NUM_BANKS   (NUM_BANKS),
      .BANK_WORDS  (BANK_WORDS),
      .HAS_ROM     (1'b1),
      .ROM_WORDS   (ROM_WORDS),
      .RAM_BASE_M0 (X_RAM_HIGH),
      .RAM_BASE_M1 (X_RAM_LOW),
      .ROM_BASE_M0 (X_ROM_LOW),
      .ROM_BASE_M1 (X_ROM_HIGH)
   ) u_xdec (
      .req      (x_req),
      .addr     (x_addr),
      .map_sel  (map_q),
      .ram_hit  (x_hit),
      .ram_offs (x_ram_offs),
      .rom_hit  (x_rom_cs)
   );

   xymd_space_dec #(
      .ADDR_W      (ADDR_W),
      .NUM_BANKS   (NUM_BANKS),
      .BANK_WORDS  (BANK_WORDS),
      .HAS_ROM     (1'b0),
      .ROM_WORDS   (ROM_WORDS),
      .RAM_BASE_M0 (Y_RAM_BASE),
      .RAM_BASE_M1 (Y_RAM_BASE),
      .ROM_BASE_M0 (0),
      .ROM_BASE_M1 (0)
   ) u_ydec (
      .req      (y_req),
      .addr     (y_addr),
      .map_sel  (map_q),
      .ram_hit  (y_hit),
      .ram_offs (y_ram_offs),
      .rom_hit  (y_rom_unused)
   );

   xymd_bank_arb #(
      .NUM_BANKS (NUM_BANKS)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .x_hit   (x_hit),
      .y_hit   (y_hit),
      .x_grant (x_ram_cs),
      .y_grant (y_ram_cs),
      .x_wait  (x_wait)
   );

   assign map_sel = map_q;

endmodule

// File: rtl/xymd_checker.sv
`timescale 1ns/1ps
module xymd_checker #(
   parameter int ADDR_W    = 16,
   parameter int NUM_BANKS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 x_req,
   input logic [ADDR_W-1:0]    x_addr,
   input logic                 x_rom_cs,
   input logic [NUM_BANKS-1:0] x_ram_cs,
   input logic [NUM_BANKS-1:0] y_ram_cs,
   input logic                 x_wait,
   input logic                 map_sel,
   input logic                 trap_active
);

   AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      x_wait |=> !x_wait); // R10

   AST_Y_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      x_wait |-> (x_ram_cs == '0 && y_ram_cs != '0)); // R9

   AST_NO_SHARED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (x_ram_cs & y_ram_cs) == '0); // R8

   AST_X_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({x_rom_cs, x_ram_cs})); // R3

   AST_Y_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(y_ram_cs)); // R5

   AST_X_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !x_req |-> (!x_rom_cs && x_ram_cs == '0 && !x_wait)); // R7

   AST_TRAP_DEFAULT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trap_active) |-> !map_sel); // R11

   AST_HELD_X_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(x_wait) && x_req && $stable(x_addr) && $stable(map_sel)) |-> x_ram_cs != '0); // R10

endmodule

bind xy_mem_decoder xymd_checker #(
   .ADDR_W    (ADDR_W),
   .NUM_BANKS (NUM_BANKS)
) u_xymd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .x_req       (x_req),
   .x_addr      (x_addr),
   .x_rom_cs    (x_rom_cs),
   .x_ram_cs    (x_ram_cs),
   .y_ram_cs    (y_ram_cs),
   .x_wait      (x_wait),
   .map_sel     (map_sel),
   .trap_active (trap_active)
);

// File: tb/xy_mem_decoder_bench.sv
`timescale 1ns/1ps
module xy_mem_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        trap_enter = 1'b0;
   logic        trap_done = 1'b0;
   logic        x_req = 1'b0;
   logic [15:0] x_addr = '0;
   logic        y_req = 1'b0;
   logic [15:0] y_addr = '0;
   logic        x_rom_cs;
   logic [1:0]  x_ram_cs;
   logic [9:0]  x_ram_offs;
   logic [1:0]  y_ram_cs;
   logic [9:0]  y_ram_offs;
   logic        x_wait;
   logic        map_sel;
   logic        trap_active;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // bench model of the requirements
   logic map_m = 1'b0, save_m = 1'b0, trap_m = 1'b0, slot_m = 1'b0;

   always #4 clk = ~clk;

   xy_mem_decoder u_xy_mem_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .trap_enter(trap_enter), .trap_done(trap_done),
      .x_req(x_req), .x_addr(x_addr), .y_req(y_req), .y_addr(y_addr),
      .x_rom_cs(x_rom_cs), .x_ram_cs(x_ram_cs), .x_ram_offs(x_ram_offs),
      .y_ram_cs(y_ram_cs), .y_ram_offs(y_ram_offs), .x_wait(x_wait),
      .map_sel(map_sel), .trap_active(trap_active)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // X decode per R3/R4: {rom, bank1, bank0}
   function automatic logic [2:0] x_expect(input logic [15:0] a, input logic m);
      logic [15:0] rel, rrel;
      logic [2:0]  r;
      rel  = a - (m ? 16'h0000 : 16'hC000);
      rrel = a - (m ? 16'h4000 : 16'h0000);
      r = 3'b000;
      if (rel < 16'd2048) r[rel[10]] = 1'b1;
      if (rrel < 16'd24576) r[2] = 1'b1;
      return r;
   endfunction

   // Y decode per R5
   function automatic logic [1:0] y_expect(input logic [15:0] a);
      logic [1:0] r;
      r = 2'b00;
      if (a < 16'd2048) r[a[10]] = 1'b1;
      return r;
   endfunction

   task automatic step(input logic xr, input logic [15:0] xa,
                       input logic yr, input logic [15:0] ya,
                       input logic cw, input logic [15:0] cd,
                       input logic te, input logic td);
      logic [2:0] xd;
      logic [1:0] yd, exp_x, exp_y;
      logic       conflict;
      string      xtag;
      @(negedge clk);
      x_req = xr; x_addr = xa; y_req = yr; y_addr = ya;
      cfg_wr = cw; cfg_wdata = cd; trap_enter = te; trap_done = td;
      #1;
      xd = xr ? x_expect(xa, map_m) : 3'b000;
      yd = yr ? y_expect(ya) : 2'b00;
      conflict = !slot_m && ((xd[1:0] & yd) != 2'b00);
      exp_x = conflict ? 2'b00 : xd[1:0];
      exp_y = slot_m ? (yd & ~xd[1:0]) : yd;
      xtag = !xr ? "R7" : (slot_m ? "R10" : (map_m ? "R4" : "R3"));
      chk(map_sel == map_m, trap_m ? "R11" : "R2", "map_sel", map_sel, map_m);
      chk(trap_active == trap_m, "R12", "trap_active", trap_active, trap_m);
      chk(x_wait == conflict, conflict ? "R9" : "R8", "x_wait", x_wait, conflict);
      chk(x_ram_cs == exp_x, xtag, "x_ram_cs", x_ram_cs, exp_x);
      chk(x_rom_cs == xd[2], map_m ? "R4" : "R3", "x_rom_cs", x_rom_cs, xd[2]);
      chk(y_ram_cs == exp_y, slot_m ? "R10" : "R5", "y_ram_cs", y_ram_cs, exp_y);
      if (exp_x != 2'b00) chk(x_ram_offs == xa[9:0], "R6", "x_ram_offs", x_ram_offs, xa[9:0]);
      if (exp_y != 2'b00) chk(y_ram_offs == ya[9:0], "R6", "y_ram_offs", y_ram_offs, ya[9:0]);
      // model update for the next edge (R11, R12, R13, R2)
      slot_m = conflict;
      if (te && !trap_m) begin
         save_m = map_m; map_m = 1'b0; trap_m = 1'b1;
      end else if (td && trap_m) begin
         map_m = save_m; trap_m = 1'b0;
      end else if (cw) begin
         map_m = cd[14];
      end
   endtask

   task automatic idle();
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
   endtask

   function automatic logic [15:0] pick_addr();
      logic [15:0] r;
      r = 16'($urandom);
      case ($urandom % 4)
         0: return r;
         1: return {5'b00000, r[10:0]};
         2: return {5'b11000, r[10:0]};
         default: return 16'h3F00 + 16'(r % 16'h6200);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(map_sel == 1'b0, "R1", "map_sel after reset", map_sel, 0);
      chk(trap_active == 1'b0, "R1", "trap_active after reset", trap_active, 0);
      chk(x_wait == 1'b0, "R1", "x_wait after reset", x_wait, 0);

      // R3: map 0 edges
      step(1'b1, 16'hC000, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'hC3FF, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'hC400, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'hC800, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h5FFF, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h6000, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      // R2: write with bit 14 clear and all other bits set keeps map 0
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'hBFFF, 1'b0, 1'b0);
      idle();
      // R2/R4: set map 1, then edges
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h4000, 1'b0, 1'b0);
      step(1'b1, 16'h0000, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h07FF, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h3FFF, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h4000, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h9FFF, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'hC000, 1'b1, 16'h0412, 1'b0, 16'h0, 1'b0, 1'b0);
      // R8: different banks together; R9/R10: same-bank collisions back to back
      step(1'b1, 16'h0010, 1'b1, 16'h0420, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h0123, 1'b1, 16'h0321, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h0123, 1'b1, 16'h0322, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h0123, 1'b1, 16'h0323, 1'b0, 16'h0, 1'b0, 1'b0);
      step(1'b1, 16'h0123, 1'b1, 16'h0324, 1'b0, 16'h0, 1'b0, 1'b0);
      idle();
      // R11/R12: trap with map 1, write 0 inside, restore gives map 1
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0);
      step(1'b1, 16'hC001, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0);
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0000, 1'b0, 1'b0);
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1);
      idle();
      chk(map_sel == 1'b1, "R12", "map restored after trap", map_sel, 1);
      chk(trap_active == 1'b0, "R12", "trap cleared", trap_active, 0);
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1);
      // R13: trap entry and write in one cycle, map 1 -> write 0 ignored, saved 1
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0000, 1'b1, 1'b0);
      step(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1);
      idle();
      chk(map_sel == 1'b1, "R13", "map after entry+write then done", map_sel, 1);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 5) != 0, pick_addr(), ($urandom % 5) != 0, pick_addr(),
              ($urandom % 12) == 0, 16'($urandom),
              ($urandom % 40) == 0, ($urandom % 40) == 0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule